// File: doc/BRIEF.md
# Master-Clock to Sample-Rate Ratio Detector

This block runs on the converter's master clock and watches the sample-rate (left/right word) clock. It counts master-clock cycles between successive rising edges of that clock and maps the count onto one of six supported ratios: 128, 192, 256, 384, 512 or 768 master-clock cycles per sample. No register or pin selects the ratio; the result is derived entirely from the incoming clocks.

The two smallest ratios put the rest of the converter into high-rate operation, which halves the oversampling ratio from 128 to 64. A lock flag tells the downstream logic when the classification has been stable long enough to be trusted. If the word clock stops, or its period fits none of the ratios, the block reports an unsupported ratio and drops lock.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While and after reset, ratio_code is 0, locked is 0, high_rate is 0 and osr is 128.
- R2: The word clock passes through a two-flop synchroniser; a period is the number of master-clock cycles between two successive rising edges, and the outputs take the new result on the third master-clock rising edge after the word-clock input rises.
- R3: A period within ±2 cycles of a nominal ratio gives ratio_code 1 for 128, 2 for 192, 3 for 256, 4 for 384, 5 for 512 and 6 for 768; ratio_code never exceeds 6.
- R4: A period more than 2 cycles away from every nominal ratio gives ratio_code 0 (unsupported).
- R5: For ratio_code 1 or 2, high_rate is 1 and osr is 64; for every other code high_rate is 0 and osr is 128.
- R6: locked rises when three consecutive periods give the same non-zero code, and not earlier.
- R7: locked falls on the first period whose code differs from the previous one or is 0.
- R8: If no rising word-clock edge arrives within 2048 master-clock cycles of the last one, ratio_code becomes 0 and locked becomes 0.
- R9: The first rising edge after reset or after a timeout only starts a measurement; classification begins at the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, also the block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk | input | 1 | Sample-rate (word) clock, asynchronous to mclk |
| ratio_code | output | 3 | Detected ratio: 0 unsupported, 1..6 for 128, 192, 256, 384, 512, 768 |
| high_rate | output | 1 | High-rate operation selected (ratio 128 or 192) |
| osr | output | 8 | Selected oversampling ratio, 64 or 128 |
| locked | output | 1 | Same supported ratio seen for three consecutive periods |

## Verification
A new classification appears on the third master-clock edge after the word-clock input rises: two edges for the synchroniser and one for the result registers; the bench drives the word clock on falling edges and samples on falling edges, checking once after two edges (old value still held) and once after three (new value). Lock follows the third matching period, so every table vector applies four periods and samples just before the next rising edge, when all results are settled. The timeout is checked well inside and well past the 2048-cycle window rather than on its exact edge, and re-arming is checked one full period after the edge that restarts measurement.

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect #(
  parameter int TIMEOUT_CYC  = 2048,
  parameter int TOL          = 2,
  parameter int LOCK_PERIODS = 3,
  parameter int OSR_NORMAL   = 128
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       lrclk,
  output logic [2:0] ratio_code,
  output logic       high_rate,
  output logic [7:0] osr,
  output logic       locked
);

  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam int SW = $clog2(LOCK_PERIODS + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(TIMEOUT_CYC);

  logic [2:0]    sync;
  logic [CW-1:0] cnt;
  logic          armed;
  logic [SW-1:0] streak, nxt_streak;
  logic [2:0]    new_code;
  logic          rise, timeout_evt;

  function automatic logic [2:0] classify(input logic [CW-1:0] n);
    int nom;
    classify = 3'd0;
    for (int i = 1; i <= 6; i++) begin
      nom = ((i % 2) == 1 ? 128 : 192) << ((i - 1) / 2);
      if (int'(n) >= nom - TOL && int'(n) <= nom + TOL) classify = 3'(i);
    end
  endfunction

  assign rise        = sync[1] & ~sync[2];
  assign timeout_evt = armed & ~rise & (cnt == CNT_MAX);
  assign new_code    = classify(cnt);
  assign nxt_streak  = (new_code == 3'd0) ? '0 :
                       (new_code == ratio_code && streak != '0) ?
                         ((streak == SW'(LOCK_PERIODS)) ? streak : streak + SW'(1)) :
                       SW'(1);
  assign high_rate   = (ratio_code == 3'd1) || (ratio_code == 3'd2);
  assign osr         = high_rate ? 8'(OSR_NORMAL / 2) : 8'(OSR_NORMAL);

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      sync       <= '0;
      cnt        <= '0;
      armed      <= 1'b0;
      streak     <= '0;
      ratio_code <= 3'd0;
      locked     <= 1'b0;
    end else begin
      sync <= {sync[1:0], lrclk};
      if (rise) begin
        cnt   <= CW'(1);
        armed <= 1'b1;
        if (armed) begin
          ratio_code <= new_code;
          streak     <= nxt_streak;
          locked     <= (nxt_streak == SW'(LOCK_PERIODS));
        end
      end else begin
        if (cnt != CNT_MAX) cnt <= cnt + CW'(1);
        if (timeout_evt) begin
          armed      <= 1'b0;
          ratio_code <= 3'd0;
          streak     <= '0;
          locked     <= 1'b0;
        end
      end
    end
  end

  AST_CODE_RANGE: assert property (@(posedge mclk) disable iff (!rst_n) ratio_code <= 3'd6); // R3
  AST_CODE_HOLDS: assert property (@(posedge mclk) disable iff (!rst_n)
    (!$past(rise) && !$past(timeout_evt)) |-> $stable(ratio_code)); // R2
  AST_LOCK_NEEDS_CODE: assert property (@(posedge mclk) disable iff (!rst_n)
    locked |-> ratio_code != 3'd0); // R7
  AST_CHANGE_UNLOCKS: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(ratio_code) |-> !locked); // R7
  AST_LOCK_ON_REPEAT: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(locked) |-> $stable(ratio_code)); // R6
  AST_TIMEOUT_CLEARS: assert property (@(posedge mclk) disable iff (!rst_n)
    $past(timeout_evt) |-> (ratio_code == 3'd0 && !locked)); // R8
  AST_FIRST_EDGE_ARMS: assert property (@(posedge mclk) disable iff (!rst_n)
    (rise && !armed) |=> $stable(ratio_code)); // R9

endmodule

// File: tb/mclk_ratio_detect_tb.sv
module mclk_ratio_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  localparam int VEC_N[NV] = '{128, 192, 256, 384, 512, 768, 130, 254, 771, 509, 300, 766, 190};
  localparam int VEC_C[NV] = '{1,   2,   3,   4,   5,   6,   1,   3,   0,   0,   0,   6,   2};

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lrclk = 1'b0;
  logic [2:0] ratio_code;
  logic       high_rate;
  logic [7:0] osr;
  logic       locked;
  int applied = 0;
  int miscompares = 0;

  mclk_ratio_detect u_dut (
    .mclk(mclk), .rst_n(rst_n), .lrclk(lrclk),
    .ratio_code(ratio_code), .high_rate(high_rate), .osr(osr), .locked(locked)
  );

  always #(CLK_PERIOD / 2) mclk = ~mclk;

  task automatic check(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic period(input int n);
    lrclk = 1'b1;
    repeat (n / 2) @(negedge mclk);
    lrclk = 1'b0;
    repeat (n - n / 2) @(negedge mclk);
  endtask

  task automatic do_reset();
    lrclk = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge mclk);
    rst_n = 1'b1;
    @(negedge mclk);
  endtask

  initial begin
    repeat (200000) @(posedge mclk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    @(negedge mclk);
    check("R1 code in reset", ratio_code, 0);
    check("R1 locked in reset", locked, 0);
    do_reset();
    check("R1 code", ratio_code, 0);
    check("R1 locked", locked, 0);
    check("R1 high_rate", high_rate, 0);
    check("R1 osr", osr, 128);

    for (int v = 0; v < NV; v++) begin
      repeat (4) period(VEC_N[v]);
      check((VEC_C[v] == 0) ? "R4 unsupported code" : "R3 code", ratio_code, VEC_C[v]);
      check("R6 locked after three periods", locked, (VEC_C[v] != 0) ? 1 : 0);
      check("R5 high_rate", high_rate, (VEC_C[v] == 1 || VEC_C[v] == 2) ? 1 : 0);
      check("R5 osr", osr, (VEC_C[v] == 1 || VEC_C[v] == 2) ? 64 : 128);
    end

    do_reset();
    period(512);
    check("R9 first edge only arms", ratio_code, 0);
    repeat (2) period(512);
    check("R3 code 512", ratio_code, 5);
    check("R6 not locked after two", locked, 0);
    period(512);
    check("R6 locked after three", locked, 1);
    period(300);
    check("R6 still locked", locked, 1);
    period(512);
    check("R7 unsupported period code", ratio_code, 0);
    check("R7 unsupported drops lock", locked, 0);
    repeat (3) period(512);
    check("R6 relock", locked, 1);
    period(256);
    lrclk = 1'b1;
    repeat (2) @(negedge mclk);
    check("R2 code held two edges", ratio_code, 5);
    check("R2 lock held two edges", locked, 1);
    @(negedge mclk);
    check("R2 code on third edge", ratio_code, 3);
    check("R7 mismatch drops lock", locked, 0);

    repeat (10) @(negedge mclk);
    lrclk = 1'b0;
    repeat (1980) @(negedge mclk);
    check("R8 code before timeout", ratio_code, 3);
    repeat (100) @(negedge mclk);
    check("R8 timeout code", ratio_code, 0);
    check("R8 timeout locked", locked, 0);
    period(256);
    check("R9 edge after timeout arms only", ratio_code, 0);
    period(256);
    check("R9 classify after rearm", ratio_code, 3);
    check("R6 not locked after rearm", locked, 0);

    rst_n = 1'b0;
    @(negedge mclk);
    check("R1 async reset code", ratio_code, 0);
    check("R1 async reset osr", osr, 128);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule